// File: doc/BRIEF.md
# OTP Shadow and Program Controller

This block is a register-mapped front end for a one-time-programmable fuse array. Software uses it to copy a fuse word into a per-word shadow register, to OR new bits into a fuse word, or to burn a permanent lock for a word. For each word it keeps sticky lock bits that block reloads, shadow writes and programming, and it reports the outcome of every command in per-word error and disturbed bits.

The fuse array sits outside the block, behind a request stream and a response strobe. A request carries a read/write flag, a lock flag, an address and a data word. It uses valid/ready. Once `fz_req_valid` is high, the address, data and flags hold steady until the cycle in which `fz_req_ready` is sampled high. After that handshake the block waits for one `fz_rsp_valid` pulse. There is no ready on the response side: the block accepts a response in any cycle while it is waiting. Power to the array is requested by a configuration bit, and the array's power-good pin is reported back as a status bit.

Software sees 32-bit words on a plain register port. A write is applied on the clock edge while `bus_we` is high. `bus_rdata` is a combinational function of `bus_addr`.

Top module: `otpc_ctrl`

## Requirements
- R1: After reset, all of the following are zero: STATUS (0x00C), every lock, error and disturbed bank, every shadow word, `fz_pwr_req` and `fz_req_valid`.
- R2: The shadow-read, shadow-write and shadow-program lock banks sit at 0x100, 0x140 and 0x180 plus bank×4. Bank = word index / 32 and bit = word index mod 32. Writing a 1 sets the lock for that word. Writing a 0 leaves it unchanged. A lock stays set until reset.
- R3: CTRL (0x004) holds the word index in bits [5:0] and the command in bits [9:8] (1 read, 2 program, 3 permanent lock). A read command sets STATUS bit 0 (busy) and issues a fuse read of that word. Busy stays set until the response arrives. A response without error copies the fuse data into that word's shadow register.
- R4: When a command completes, the word's bit in the error bank (0x240 + bank×4) takes the response error flag. Its bit in the disturbed bank (0x280 + bank×4) takes the disturbed flag, except that an error clears the disturbed bit.
- R5: A program command issues a fuse write of the word with the value last written to WRDATA (0x008). STATUS bit 2 (program fail) is cleared when the command is issued and is set if the response reports an error.
- R6: A program command to a word whose shadow-program lock or permanent lock is set issues no fuse request. It sets program fail and leaves the fuse word unchanged.
- R7: CONF (0x000) bit 0 drives `fz_pwr_req`. STATUS bit 1 reflects `fz_pwr_ok`.
- R8: Shadow word i reads at 0x400 + i×4 and can be written there. While the word's shadow-write lock is set, a bus write to it is ignored.
- R9: While `otp_invalid` is high, STATUS bit 3 is set and shadow reads return 0. Bus writes to shadow words are ignored. Every command issues no request and sets the error bit of its word.
- R10: A permanent-lock command issues a write request with the lock flag set. For a word below 32, the row is index/16 and the data is 0b11 shifted left by 2×(index mod 16). For a word at 32 or above, the row is index/32 + 2 and the data is 1 shifted left by (index mod 32). On success the word's bit in the permanent-lock bank (0x1C0 + bank×4) is set.
- R11: A command issued while busy, or while `fz_pwr_ok` is low, issues no request. It sets the error bit and clears the disturbed bit of its own word, and it does not disturb the command in flight.
- R12: A read command to a word whose shadow-read lock is set issues no request and does not change that word's shadow value.
- R13: While `fz_req_valid` is high and `fz_req_ready` is low, the request stays valid and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| otp_invalid | input | 1 | Array is in the invalid mode |
| fz_pwr_req | output | 1 | Power-up request to the array |
| fz_pwr_ok | input | 1 | Array power is good |
| fz_req_valid | output | 1 | Fuse request valid |
| fz_req_ready | input | 1 | Fuse request accepted |
| fz_req_write | output | 1 | Request is a write (program or lock) |
| fz_req_lock | output | 1 | Request targets a lock row |
| fz_req_addr | output | IDXW (6) | Word index or lock row |
| fz_req_data | output | 32 | Bits to OR into the target |
| fz_rsp_valid | input | 1 | Response strobe |
| fz_rsp_data | input | 32 | Fuse word read back |
| fz_rsp_err | input | 1 | Command failed |
| fz_rsp_dist | input | 1 | Read value was disturbed |

## Verification
Most wrong internal states in this block show up the next time software looks. A lock bit that is lost or set on the wrong word shows up at once in the bank read-back. It also shows up at the next command to that word, as a fuse request that should have been refused, or one that went missing. A sequencer that leaves its idle state early or late shows up in the cycle after the response, in the busy bit and in the shadow value, which is read right after the response is consumed. Corrupted request fields while the array applies back-pressure are caught on every stalled cycle. Errors that are written to the wrong word are exposed by reading back the error and disturbed banks after each command.

// File: rtl/otpc_pkg.sv
package otpc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_READ = 2'd1,
    CMD_PROG = 2'd2,
    CMD_LOCK = 2'd3
  } otpc_cmd_e;

  localparam logic [11:0] A_CONF  = 12'h000;
  localparam logic [11:0] A_CTRL  = 12'h004;
  localparam logic [11:0] A_WDATA = 12'h008;
  localparam logic [11:0] A_STAT  = 12'h00C;

  // 64-byte groups selected by bus_addr[11:6]
  localparam logic [5:0] G_LOCK0 = 6'd4;   // rd, wr, pg, perm at 4..7
  localparam logic [5:0] G_ERR   = 6'd9;
  localparam logic [5:0] G_DIST  = 6'd10;

  localparam int KINDS = 4;
  localparam int K_RD  = 0;
  localparam int K_WR  = 1;
  localparam int K_PG  = 2;
  localparam int K_PM  = 3;
endpackage

// File: rtl/otpc_sticky.sv
module otpc_sticky #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  output logic [WIDTH-1:0] bits_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_o <= '0;
    else        bits_o <= bits_o | set_i;
  end
endmodule

// File: rtl/otpc_seq.sv
module otpc_seq
  import otpc_pkg::*;
#(
  parameter  int NWORDS = 64,
  parameter  int UPPER  = 32,
  localparam int IDXW   = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  otpc_cmd_e         cmd_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [31:0]       wdata_i,
  input  logic              powered_i,
  input  logic              invalid_i,
  input  logic [NWORDS-1:0] rdlock_i,
  input  logic [NWORDS-1:0] pglock_i,
  input  logic [NWORDS-1:0] pmlock_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic              req_lock_o,
  output logic [IDXW-1:0]   req_addr_o,
  output logic [31:0]       req_data_o,
  input  logic              rsp_valid_i,
  output logic              done_o,
  output otpc_cmd_e         done_cmd_o,
  output logic [IDXW-1:0]   done_idx_o,
  output logic              reject_o,
  output logic              refuse_o,
  output logic              issue_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e st;
  otpc_cmd_e cmd_q;
  logic [IDXW-1:0] idx_q;

  logic bad, blocked, skip, go;
  logic [IDXW-1:0] row;
  logic [31:0] pat;

  assign busy_o  = (st != S_IDLE);
  assign bad     = invalid_i | busy_o | !powered_i;
  assign blocked = (cmd_i == CMD_PROG) & (pglock_i[idx_i] | pmlock_i[idx_i]);
  assign skip    = (cmd_i == CMD_READ) & rdlock_i[idx_i];
  assign reject_o = start_i & bad;
  assign refuse_o = start_i & !bad & blocked;
  assign go       = start_i & !bad & !blocked & !skip;
  assign issue_o  = go & (cmd_i != CMD_READ);

  assign req_valid_o = (st == S_ISSUE);
  assign done_o      = (st == S_WAIT) & rsp_valid_i;
  assign done_cmd_o  = cmd_q;
  assign done_idx_o  = idx_q;

  // lock-row mapping: two bits per lower word, one per upper word
  always_comb begin
    if (int'(idx_i) < UPPER) begin
      row = IDXW'(idx_i >> 4);
      pat = 32'h3 << {idx_i[3:0], 1'b0};
    end else begin
      row = IDXW'((idx_i >> 5) + 2);
      pat = 32'h1 << idx_i[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cmd_q       <= CMD_NONE;
      idx_q       <= '0;
      req_write_o <= 1'b0;
      req_lock_o  <= 1'b0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st          <= S_ISSUE;
          cmd_q       <= cmd_i;
          idx_q       <= idx_i;
          req_write_o <= (cmd_i != CMD_READ);
          req_lock_o  <= (cmd_i == CMD_LOCK);
          req_addr_o  <= (cmd_i == CMD_LOCK) ? row : idx_i;
          req_data_o  <= (cmd_i == CMD_LOCK) ? pat :
                         (cmd_i == CMD_PROG) ? wdata_i : 32'h0;
        end
        S_ISSUE: if (req_ready_i) st <= S_WAIT;
        S_WAIT:  if (rsp_valid_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otpc_ctrl.sv
module otpc_ctrl
  import otpc_pkg::*;
#(
  parameter  int NWORDS = 64,   // multiple of 32, at most 256
  parameter  int UPPER  = 32,
  localparam int IDXW   = $clog2(NWORDS),
  localparam int NBANKS = NWORDS / 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [11:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            otp_invalid,
  output logic            fz_pwr_req,
  input  logic            fz_pwr_ok,
  output logic            fz_req_valid,
  input  logic            fz_req_ready,
  output logic            fz_req_write,
  output logic            fz_req_lock,
  output logic [IDXW-1:0] fz_req_addr,
  output logic [31:0]     fz_req_data,
  input  logic            fz_rsp_valid,
  input  logic [31:0]     fz_rsp_data,
  input  logic            fz_rsp_err,
  input  logic            fz_rsp_dist
);
  logic [31:0] wdata_q;
  logic [31:0] shadow_q [NWORDS];
  logic [NWORDS-1:0] err_q, dist_q;
  logic progfail_q;
  logic [KINDS-1:0][NWORDS-1:0] set_v, lock_v;
  logic [NWORDS-1:0] rd_lock, wr_lock, pg_lock, pm_lock;

  logic [5:0] grp;
  logic [3:0] bnk;
  logic aligned, shd_hit, shd_we, start;
  logic [IDXW-1:0] shd_idx, cmd_idx;
  otpc_cmd_e cmd;

  logic busy, done, reject, refuse, issue;
  otpc_cmd_e done_cmd;
  logic [IDXW-1:0] done_idx;

  assign grp     = bus_addr[11:6];
  assign bnk     = bus_addr[5:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign shd_hit = aligned && (bus_addr[11:10] == 2'b01) && (int'(bus_addr[9:2]) < NWORDS);
  assign shd_idx = bus_addr[IDXW+1:2];
  assign shd_we  = bus_we && shd_hit && !otp_invalid && !lock_v[K_WR][shd_idx];
  assign cmd     = otpc_cmd_e'(bus_wdata[9:8]);
  assign cmd_idx = bus_wdata[IDXW-1:0];
  assign start   = bus_we && (bus_addr == A_CTRL) && (cmd != CMD_NONE);

  assign rd_lock = lock_v[K_RD];
  assign wr_lock = lock_v[K_WR];
  assign pg_lock = lock_v[K_PG];
  assign pm_lock = lock_v[K_PM];

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    if (k != K_PM) begin : g_bus
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign set_v[k][b*32 +: 32] =
          (bus_we && aligned && grp == 6'(G_LOCK0 + k) && bnk == 4'(b)) ? bus_wdata : 32'h0;
      end
    end else begin : g_perm
      assign set_v[k] = (done && done_cmd == CMD_LOCK && !fz_rsp_err) ?
                        (NWORDS'(1) << done_idx) : '0;
    end
    otpc_sticky #(.WIDTH(NWORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[k]), .bits_o(lock_v[k])
    );
  end

  otpc_seq #(.NWORDS(NWORDS), .UPPER(UPPER)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .cmd_i(cmd), .idx_i(cmd_idx), .wdata_i(wdata_q),
    .powered_i(fz_pwr_ok), .invalid_i(otp_invalid),
    .rdlock_i(lock_v[K_RD]), .pglock_i(lock_v[K_PG]), .pmlock_i(lock_v[K_PM]),
    .busy_o(busy),
    .req_valid_o(fz_req_valid), .req_ready_i(fz_req_ready),
    .req_write_o(fz_req_write), .req_lock_o(fz_req_lock),
    .req_addr_o(fz_req_addr), .req_data_o(fz_req_data),
    .rsp_valid_i(fz_rsp_valid),
    .done_o(done), .done_cmd_o(done_cmd), .done_idx_o(done_idx),
    .reject_o(reject), .refuse_o(refuse), .issue_o(issue)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fz_pwr_req <= 1'b0;
      wdata_q    <= '0;
      err_q      <= '0;
      dist_q     <= '0;
      progfail_q <= 1'b0;
      for (int i = 0; i < NWORDS; i++) shadow_q[i] <= '0;
    end else begin
      if (bus_we && bus_addr == A_CONF)  fz_pwr_req <= bus_wdata[0];
      if (bus_we && bus_addr == A_WDATA) wdata_q    <= bus_wdata;
      if (shd_we) shadow_q[shd_idx] <= bus_wdata;
      if (done) begin
        err_q[done_idx]  <= fz_rsp_err;
        dist_q[done_idx] <= fz_rsp_dist & !fz_rsp_err;
        if (done_cmd == CMD_READ && !fz_rsp_err) shadow_q[done_idx] <= fz_rsp_data;
        if (done_cmd != CMD_READ && fz_rsp_err)  progfail_q <= 1'b1;
      end
      if (reject) begin
        err_q[cmd_idx]  <= 1'b1;
        dist_q[cmd_idx] <= 1'b0;
      end
      if (issue)  progfail_q <= 1'b0;
      if (refuse) progfail_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == A_CONF)  bus_rdata = {31'h0, fz_pwr_req};
    if (bus_addr == A_WDATA) bus_rdata = wdata_q;
    if (bus_addr == A_STAT)  bus_rdata = {28'h0, otp_invalid, progfail_q, fz_pwr_ok, busy};
    for (int b = 0; b < NBANKS; b++) begin
      if (aligned && bnk == 4'(b)) begin
        for (int k = 0; k < KINDS; k++)
          if (grp == 6'(G_LOCK0 + k)) bus_rdata = lock_v[k][b*32 +: 32];
        if (grp == G_ERR)  bus_rdata = err_q[b*32 +: 32];
        if (grp == G_DIST) bus_rdata = dist_q[b*32 +: 32];
      end
    end
    if (shd_hit) bus_rdata = otp_invalid ? 32'h0 : shadow_q[shd_idx];
  end
endmodule

// File: rtl/otpc_chk.sv
module otpc_chk #(
  parameter  int NWORDS = 64,
  localparam int IDXW   = $clog2(NWORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              otp_invalid,
  input logic              fz_pwr_ok,
  input logic              fz_req_valid,
  input logic              fz_req_ready,
  input logic              fz_req_write,
  input logic              fz_req_lock,
  input logic [IDXW-1:0]   fz_req_addr,
  input logic [31:0]       fz_req_data,
  input logic [NWORDS-1:0] rd_lock,
  input logic [NWORDS-1:0] pg_lock,
  input logic [NWORDS-1:0] pm_lock,
  input logic [NWORDS-1:0] err_q,
  input logic [NWORDS-1:0] dist_q
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fz_req_valid && !fz_req_ready |=> fz_req_valid && $stable(fz_req_addr) &&
      $stable(fz_req_data) && $stable(fz_req_write) && $stable(fz_req_lock));

  a_r11_issue_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fz_req_valid) |-> $past(fz_pwr_ok));

  a_r9_issue_valid_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fz_req_valid) |-> !$past(otp_invalid));

  a_r6_prog_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fz_req_valid) && fz_req_write && !fz_req_lock |->
      !pg_lock[fz_req_addr] && !pm_lock[fz_req_addr]);

  a_r12_read_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fz_req_valid) && !fz_req_write |-> !rd_lock[fz_req_addr]);

  a_r4_err_over_dist: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & dist_q) == '0);

  a_r2_locks_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_lock & $past(rd_lock)) == $past(rd_lock)) &&
    ((pg_lock & $past(pg_lock)) == $past(pg_lock)));
endmodule

bind otpc_ctrl otpc_chk #(.NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .otp_invalid(otp_invalid), .fz_pwr_ok(fz_pwr_ok),
  .fz_req_valid(fz_req_valid), .fz_req_ready(fz_req_ready),
  .fz_req_write(fz_req_write), .fz_req_lock(fz_req_lock),
  .fz_req_addr(fz_req_addr), .fz_req_data(fz_req_data),
  .rd_lock(rd_lock), .pg_lock(pg_lock), .pm_lock(pm_lock),
  .err_q(err_q), .dist_q(dist_q)
);

// File: tb/otpc_ctrl_tb.sv
module otpc_ctrl_tb;
  localparam int NW = 64;
  localparam logic [11:0] CONF = 12'h000, CTRL = 12'h004, WDAT = 12'h008, STAT = 12'h00C;
  localparam logic [11:0] B_RD = 12'h100, B_WR = 12'h140, B_PG = 12'h180, B_PM = 12'h1C0;
  localparam logic [11:0] B_ERR = 12'h240, B_DIST = 12'h280, B_SHD = 12'h400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, bus_we = 1'b0, otp_invalid = 1'b0, fz_pwr_ok = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fz_pwr_req, fz_req_valid, fz_req_write, fz_req_lock;
  logic fz_req_ready = 1'b0, fz_rsp_valid = 1'b0, fz_rsp_err = 1'b0, fz_rsp_dist = 1'b0;
  logic [5:0] fz_req_addr;
  logic [31:0] fz_req_data, fz_rsp_data = '0;

  otpc_ctrl #(.NWORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .otp_invalid(otp_invalid),
    .fz_pwr_req(fz_pwr_req), .fz_pwr_ok(fz_pwr_ok),
    .fz_req_valid(fz_req_valid), .fz_req_ready(fz_req_ready),
    .fz_req_write(fz_req_write), .fz_req_lock(fz_req_lock),
    .fz_req_addr(fz_req_addr), .fz_req_data(fz_req_data),
    .fz_rsp_valid(fz_rsp_valid), .fz_rsp_data(fz_rsp_data),
    .fz_rsp_err(fz_rsp_err), .fz_rsp_dist(fz_rsp_dist)
  );

  int vecs = 0, miss = 0;
  logic mon_on = 1'b0, exp_pwr = 1'b0;
  logic [31:0] fuse [NW];
  logic [31:0] shd [NW];
  logic [31:0] lockrow [8];
  logic [NW-1:0] m_err = '0, m_dist = '0, m_rd = '0, m_wr = '0, m_pg = '0, m_pm = '0;
  logic m_pf = 1'b0;
  logic [31:0] m_wd = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) chk("R7", "pwr_req per clock", {31'h0, fz_pwr_req}, {31'h0, exp_pwr});
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    if (a == CONF) exp_pwr = d[0];
    if (a == WDAT) m_wd = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic chk_reg(input string tag, input string what, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, what, bus_rdata, exp);
  endtask

  task automatic chk_vec(input string tag, input string what, input logic [11:0] base, input logic [NW-1:0] v);
    for (int b = 0; b < 2; b++) chk_reg(tag, what, base + 12'(4*b), v[b*32 +: 32]);
  endtask

  function automatic logic [31:0] stat_exp(input logic busy);
    return {28'h0, otp_invalid, m_pf, fz_pwr_ok, busy};
  endfunction

  task automatic serve(input int c, input int idx, input bit e, input bit d, input int dly, input string tag);
    int row;
    logic [31:0] ed;
    if (c == 3) begin
      if (idx < 32) begin row = idx / 16; ed = 32'h3 << (2 * (idx % 16)); end
      else begin row = idx / 32 + 2; ed = 32'h1 << (idx % 32); end
    end else begin
      row = idx; ed = (c == 2) ? m_wd : 32'h0;
    end
    if (c != 1) m_pf = 1'b0;
    chk(tag, "req_valid", {31'h0, fz_req_valid}, 32'h1);
    chk(tag, "req_addr", {26'h0, fz_req_addr}, 32'(row));
    chk(tag, "req_data", fz_req_data, ed);
    chk(tag, "req_write", {31'h0, fz_req_write}, {31'h0, c != 1});
    chk(tag, "req_lock", {31'h0, fz_req_lock}, {31'h0, c == 3});
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); #1;
      chk("R13", "held valid", {31'h0, fz_req_valid}, 32'h1);
      chk("R13", "held addr", {26'h0, fz_req_addr}, 32'(row));
      chk("R13", "held data", fz_req_data, ed);
    end
    chk_reg("R3", "busy set", STAT, stat_exp(1'b1));
    fz_req_ready = 1'b1;
    @(negedge clk);
    fz_req_ready = 1'b0;
    fz_rsp_valid = 1'b1; fz_rsp_err = e; fz_rsp_dist = d; fz_rsp_data = fuse[idx];
    @(negedge clk);
    fz_rsp_valid = 1'b0; fz_rsp_err = 1'b0; fz_rsp_dist = 1'b0;
    #1;
    if (!e) begin
      if (c == 1) shd[idx] = fuse[idx];
      if (c == 2) fuse[idx] = fuse[idx] | m_wd;
      if (c == 3) begin lockrow[row] = lockrow[row] | ed; m_pm[idx] = 1'b1; end
    end
    m_err[idx] = e; m_dist[idx] = d & !e;
    if (c != 1) m_pf = e;
    chk_reg(tag, "busy clear", STAT, stat_exp(1'b0));
  endtask

  task automatic cmd(input int c, input int idx, input bit e, input bit d, input int dly, input string tag);
    wr(CTRL, 32'((c << 8) | idx));
    serve(c, idx, e, d, dly, tag);
  endtask

  task automatic cmd_noreq(input int c, input int idx, input string tag);
    wr(CTRL, 32'((c << 8) | idx));
    chk(tag, "no request", {31'h0, fz_req_valid}, 32'h0);
    @(negedge clk); #1;
    chk(tag, "still no request", {31'h0, fz_req_valid}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin fuse[i] = 32'(i) * 32'h0101_0003; shd[i] = '0; end
    for (int i = 0; i < 8; i++) lockrow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    mon_on = 1'b1;

    // R1 reset state
    chk_reg("R1", "status", STAT, 32'h0);
    chk_vec("R1", "read-lock bank", B_RD, '0);
    chk_vec("R1", "error bank", B_ERR, '0);
    chk_reg("R1", "shadow 5", B_SHD + 12'd20, 32'h0);
    chk("R1", "req_valid", {31'h0, fz_req_valid}, 32'h0);
    chk("R1", "pwr_req", {31'h0, fz_pwr_req}, 32'h0);

    // R7 power
    wr(CONF, 32'h1);
    chk("R7", "pwr_req", {31'h0, fz_pwr_req}, 32'h1);
    chk_reg("R7", "pwron low", STAT, 32'h0);
    fz_pwr_ok = 1'b1; #1;
    chk_reg("R7", "pwron high", STAT, 32'h2);

    // R3 shadow read with back-pressure
    cmd(1, 5, 0, 0, 3, "R3");
    chk_reg("R3", "shadow 5", B_SHD + 12'd20, shd[5]);

    // R4 disturbed, then error with priority
    cmd(1, 6, 0, 1, 0, "R4");
    cmd(1, 7, 1, 1, 1, "R4");
    chk_vec("R4", "error bank", B_ERR, m_err);
    chk_vec("R4", "disturbed bank", B_DIST, m_dist);
    chk_reg("R4", "shadow 7 kept on error", B_SHD + 12'd28, 32'h0);
    cmd(1, 7, 0, 0, 0, "R4");
    chk_vec("R4", "error cleared", B_ERR, m_err);

    // R5 program
    wr(WDAT, 32'h0000_F0F0);
    cmd(2, 9, 0, 0, 2, "R5");
    cmd(1, 9, 0, 0, 0, "R5");
    chk_reg("R5", "programmed word", B_SHD + 12'd36, fuse[9]);
    cmd(2, 11, 1, 0, 0, "R5");
    chk_reg("R5", "progfail after error", STAT, 32'h6);

    // R2 sticky lock banks
    wr(B_RD + 12'd4, 32'h0000_0008);
    m_rd[35] = 1'b1;
    chk_vec("R2", "rd-lock bank", B_RD, m_rd);
    wr(B_RD + 12'd4, 32'h0);
    chk_vec("R2", "write of zero ignored", B_RD, m_rd);

    // R12 read lock keeps shadow
    cmd(1, 40, 0, 0, 0, "R12");
    wr(B_RD + 12'd4, 32'h0000_0100);
    m_rd[40] = 1'b1;
    chk_vec("R2", "second lock bit", B_RD, m_rd);
    fuse[40] = 32'hFFFF_0000;
    cmd_noreq(1, 40, "R12");
    chk_reg("R12", "shadow 40 kept", B_SHD + 12'd160, shd[40]);

    // R8 shadow bus access and write lock
    wr(B_SHD + 12'd80, 32'h0000_1234);
    chk_reg("R8", "shadow write", B_SHD + 12'd80, 32'h0000_1234);
    wr(B_WR, 32'h0010_0000);
    wr(B_SHD + 12'd80, 32'h0000_FFFF);
    chk_reg("R8", "locked shadow write ignored", B_SHD + 12'd80, 32'h0000_1234);

    // R6 program lock
    wr(WDAT, 32'h0F00_0000);
    cmd(2, 11, 0, 0, 0, "R6");
    wr(B_PG, 32'h0000_0400);
    m_pg[10] = 1'b1;
    chk_vec("R6", "pg-lock bank", B_PG, m_pg);
    cmd_noreq(2, 10, "R6");
    m_pf = 1'b1;
    chk_reg("R6", "progfail on refusal", STAT, stat_exp(1'b0));
    cmd(1, 10, 0, 0, 0, "R6");
    chk_reg("R6", "fuse 10 untouched", B_SHD + 12'd40, shd[10]);

    // R10 permanent lock, lower and upper
    cmd(3, 12, 0, 0, 1, "R10");
    chk_vec("R10", "perm bank", B_PM, m_pm);
    cmd_noreq(2, 12, "R10");
    m_pf = 1'b1;
    chk_reg("R10", "program refused after lock", STAT, stat_exp(1'b0));
    cmd(3, 45, 0, 0, 0, "R10");
    chk_vec("R10", "perm bank upper", B_PM, m_pm);

    // R11 busy and unpowered rejection
    wr(CTRL, 32'h0000_0105);
    wr(CTRL, 32'h0000_010E);
    chk("R11", "in-flight addr kept", {26'h0, fz_req_addr}, 32'd5);
    m_err[14] = 1'b1; m_dist[14] = 1'b0;
    serve(1, 5, 0, 0, 0, "R11");
    chk_vec("R11", "error on busy", B_ERR, m_err);
    wr(CONF, 32'h0);
    fz_pwr_ok = 1'b0; #1;
    chk_reg("R11", "pwron dropped", STAT, stat_exp(1'b0));
    wr(WDAT, 32'hFFFF_FFFF);
    cmd_noreq(2, 15, "R11");
    m_err[15] = 1'b1;
    chk_vec("R11", "error when unpowered", B_ERR, m_err);
    wr(CONF, 32'h1);
    fz_pwr_ok = 1'b1;
    cmd(1, 15, 0, 0, 0, "R11");
    chk_reg("R11", "fuse 15 untouched", B_SHD + 12'd60, shd[15]);

    // R9 invalid mode
    @(negedge clk);
    otp_invalid = 1'b1; #1;
    chk_reg("R9", "status invalid", STAT, stat_exp(1'b0));
    cmd_noreq(1, 16, "R9");
    m_err[16] = 1'b1;
    chk_reg("R9", "shadow reads zero", B_SHD + 12'd20, 32'h0);
    wr(B_SHD + 12'd84, 32'h0000_DEAD);
    @(negedge clk);
    otp_invalid = 1'b0; #1;
    chk_vec("R9", "error on invalid", B_ERR, m_err);
    chk_reg("R9", "shadow write ignored", B_SHD + 12'd84, 32'h0);
    chk_reg("R9", "shadow visible again", B_SHD + 12'd20, shd[5]);

    mon_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule